// File: doc/BRIEF.md
# Protection-Checked Translation Buffer

This block is a small fully associative cache of address translations. A requester presents a virtual page number together with the kind of access: load, store or instruction fetch. In the same cycle, the block answers with one of three outcomes: a hit carrying the physical page number, a miss, or a protection fault. Every entry holds a valid flag, a virtual page tag, a modified flag, a two-bit protection code and a physical page number.

A hit counts only when the matching entry's protection code allows the requested access. A store that is allowed marks its entry as modified, and the block reports that flag on later lookups. A separate write port loads a new translation into the slot chosen by a round-robin pointer. A flush input drops every translation when the running process changes. A miss or a fault leaves the page walk and the exception handling to logic outside the block.

Top module: `tlb_prot`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss. The fill pointer starts at slot 0.
- R2: A lookup whose page matches a valid entry, with the access permitted, raises lk_hit and returns that entry's physical page on lk_ppn. When several entries match, the lowest-numbered one is used. lk_ppn is 0 whenever lk_hit is low.
- R3: An entry whose valid flag is clear never produces a hit or a fault, even when its tag equals the looked-up page.
- R4: A lookup that matches no valid entry raises lk_miss only.
- R5: Access kinds are encoded as 00 load, 01 store and 10 fetch, and 11 is handled as a load. Protection codes are 00 read-only, 01 read-write and 10 read-execute, and 11 is handled as read-only. A load is permitted under every code. A store is permitted only under 01, and a fetch only under 10.
- R6: A matching access that its entry does not permit raises lk_fault instead of lk_hit, drives lk_ppn to 0, and does not change the entry's modified flag.
- R7: A permitted store sets the matched entry's modified flag at the next clock edge. lk_mod shows the stored modified flag of the matched entry on a hit or a fault, and is 0 otherwise.
- R8: A fill writes tag, protection and physical page into the slot at the fill pointer, sets that slot valid and clears its modified flag. The pointer then advances by one, wrapping after the last slot. When a store hit and a fill address the same slot in one cycle, the fill wins.
- R9: flush clears every valid flag at the next edge. A fill in the same cycle is discarded, and the pointer does not move.
- R10: lk_hit, lk_miss and lk_fault are mutually exclusive. Exactly one of them is high while lk_valid is high, and all three are low while lk_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_kind | input | 2 | Access kind (00 load, 01 store, 10 fetch) |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No valid entry matches |
| lk_fault | output | 1 | Entry matches but access not permitted |
| lk_ppn | output | PPN_W | Physical page on a hit, else 0 |
| lk_mod | output | 1 | Modified flag of the matched entry |
| fill_en | input | 1 | Write one translation |
| fill_vpn | input | VPN_W | Tag for the filled entry |
| fill_prot | input | 2 | Protection code for the filled entry |
| fill_ppn | input | PPN_W | Physical page for the filled entry |
| flush | input | 1 | Invalidate all entries |

## Verification
Every piece of stored state appears at the ports on the next lookup of the page it belongs to. The lookup path has no register, so each entry's valid flag, protection code, physical page and modified flag can be observed one cycle after it is written. The bench therefore fills known translations and sweeps every access kind over every slot and every protection code. A wrongly set valid flag shows up as a hit or miss on the wrong page, and a wrong modified flag shows up on lk_mod at the following lookup. A fill pointer that moves when it should not shows up when the next fill lands in the wrong slot and evicts the wrong translation.

// File: rtl/tlb_prot.sv
module tlb_prot #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [1:0]       lk_kind,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_mod,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [1:0]       fill_prot,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             flush
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [1:0] K_STORE = 2'b01, K_FETCH = 2'b10;
  localparam logic [1:0] P_RW = 2'b01, P_RX = 2'b10;

  logic [ENTRIES-1:0] vld, mod, match;
  logic [VPN_W-1:0]   tag  [ENTRIES];
  logic [1:0]         prot [ENTRIES];
  logic [PPN_W-1:0]   page [ENTRIES];
  logic [PW-1:0]      ptr, sel;
  logic               any, permit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = vld[i] && (tag[i] == lk_vpn);
  end

  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) begin
        sel = PW'(i);
        any = 1'b1;
      end
  end

  assign permit = (lk_kind == K_STORE) ? (prot[sel] == P_RW) :
                  (lk_kind == K_FETCH) ? (prot[sel] == P_RX) : 1'b1;

  assign lk_hit   = lk_valid && any && permit;
  assign lk_fault = lk_valid && any && !permit;
  assign lk_miss  = lk_valid && !any;
  assign lk_ppn   = lk_hit ? page[sel] : '0;
  assign lk_mod   = (lk_valid && any) ? mod[sel] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      mod <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
    end else begin
      if (lk_hit && lk_kind == K_STORE) mod[sel] <= 1'b1;
      if (fill_en) begin
        vld[ptr] <= 1'b1;
        mod[ptr] <= 1'b0;
        ptr <= (ptr == PW'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag[ptr]  <= fill_vpn;
      prot[ptr] <= fill_prot;
      page[ptr] <= fill_ppn;
    end
  end
endmodule

module tlb_prot_chk #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [1:0]       lk_kind,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_fault,
  input logic [PPN_W-1:0] lk_ppn,
  input logic             lk_mod,
  input logic             fill_en,
  input logic             flush
);
  // R10
  exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_miss, lk_fault}));
  // R10
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault || lk_mod));
  // R2
  ppn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_ppn == '0);
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(lk_hit || lk_fault));
  // R7
  dirty_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind == 2'b01 && lk_hit && !fill_en && !flush) |=>
      ((lk_valid && lk_hit && lk_vpn == $past(lk_vpn)) |-> lk_mod));
endmodule

bind tlb_prot tlb_prot_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (.*);

// File: tb/test_tlb_prot.sv
module test_tlb_prot;
  localparam int N = 4, VW = 20, PW = 20;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, fill_en = 0, flush = 0;
  logic [1:0] lk_kind = 0, fill_prot = 0;
  logic [VW-1:0] lk_vpn = 0, fill_vpn = 0;
  logic [PW-1:0] fill_ppn = 0, lk_ppn;
  logic lk_hit, lk_miss, lk_fault, lk_mod;
  int checks = 0, errors = 0;
  bit done = 0;

  logic          m_v [N];
  logic          m_d [N];
  logic [VW-1:0] m_t [N];
  logic [1:0]    m_p [N];
  logic [PW-1:0] m_q [N];
  int            m_ptr = 0;

  always #10 clk = ~clk;

  tlb_prot #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) i_tlb_prot (.*);

  task automatic chk(string req, logic [PW+3:0] act, logic [PW+3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit allowed(logic [1:0] p, logic [1:0] k);
    if (k == 2'b01) return p == 2'b01;
    if (k == 2'b10) return p == 2'b10;
    return 1'b1;
  endfunction

  task automatic look(string req, logic [1:0] k, logic [VW-1:0] v);
    int idx = -1;
    logic eh, em, ef, ed;
    logic [PW-1:0] ep;
    @(negedge clk);
    lk_valid = 1; lk_kind = k; lk_vpn = v;
    for (int i = N - 1; i >= 0; i--) if (m_v[i] && m_t[i] == v) idx = i;
    em = (idx < 0);
    eh = !em && allowed(m_p[idx], k);
    ef = !em && !eh;
    ep = eh ? m_q[idx] : '0;
    ed = em ? 1'b0 : m_d[idx];
    #2;
    chk(req, {lk_hit, lk_miss, lk_fault, lk_mod, lk_ppn}, {eh, em, ef, ed, ep});
    @(posedge clk);
    if (eh && k == 2'b01) m_d[idx] = 1'b1;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic fill(logic [VW-1:0] v, logic [1:0] p, logic [PW-1:0] q, bit fl);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; fill_prot = p; fill_ppn = q; flush = fl;
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      m_v[m_ptr] = 1; m_d[m_ptr] = 0; m_t[m_ptr] = v; m_p[m_ptr] = p; m_q[m_ptr] = q;
      m_ptr = (m_ptr + 1) % N;
    end
    @(negedge clk);
    fill_en = 0; flush = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_d[i] = 0; m_t[i] = 0; m_p[i] = 0; m_q[i] = 0;
    end
    #45 rst_n = 1;
    // R1 R4: empty after reset
    for (int v = 0; v < 4; v++) look("R1", 2'b00, VW'(v * 70));
    // R10: idle outputs quiet
    #3 chk("R10", {lk_hit, lk_miss, lk_fault, lk_mod, lk_ppn}, '0);
    // R3: invalid slot with tag 0 does not hit
    look("R3", 2'b00, '0);
    fill(140, 2'b01, 30, 0);
    fill(40,  2'b10, 34, 0);
    fill(200, 2'b00, 32, 0);
    fill(280, 2'b01, 31, 0);
    // R2 R5 R6 R7: every kind against every slot, twice so dirty shows
    for (int r = 0; r < 2; r++)
      for (int e = 0; e < N; e++)
        for (int k = 0; k < 4; k++) look("R5", 2'(k), m_t[e]);
    look("R4", 2'b01, 30);
    look("R4", 2'b10, 141);
    // R8: fifth fill replaces slot 0, clears dirty
    fill(500, 2'b10, 7, 0);
    look("R8", 2'b00, 140);
    look("R8", 2'b10, 500);
    look("R7", 2'b01, 500);
    look("R8", 2'b00, 280);
    // R9: flush with fill discards fill, keeps pointer
    fill(900, 2'b01, 9, 1);
    for (int v = 0; v < 3; v++) look("R9", 2'b00, v == 0 ? VW'(900) : v == 1 ? VW'(500) : VW'(280));
    fill(77, 2'b11, 5, 0);
    look("R9", 2'b00, 77);
    // R5: code 11 acts read-only
    for (int k = 0; k < 4; k++) look("R5", 2'(k), 77);
    // R2: duplicate tags, lowest slot wins
    fill(77, 2'b01, 6, 0);
    look("R2", 2'b00, 77);
    fill(60, 2'b01, 8, 0);
    fill(61, 2'b01, 9, 0);
    fill(62, 2'b01, 10, 0);
    look("R2", 2'b01, 77);
    look("R7", 2'b00, 77);
    // R8: store hit and fill to the same slot, fill wins
    @(negedge clk);
    lk_valid = 1; lk_kind = 2'b01; lk_vpn = 77;
    fill_en = 1; fill_vpn = 77; fill_prot = 2'b01; fill_ppn = 12; // slot 2
    @(posedge clk);
    m_v[m_ptr] = 1; m_d[m_ptr] = 0; m_t[m_ptr] = 77; m_p[m_ptr] = 2'b01; m_q[m_ptr] = 12;
    m_ptr = (m_ptr + 1) % N;
    @(negedge clk);
    fill_en = 0; lk_valid = 0;
    look("R8", 2'b00, 77);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule